// File: doc/BRIEF.md
# Saturating Fractional Multiply-Accumulate Register

This block holds a 36-bit signed accumulator for fixed-point signal-processing arithmetic. On each accumulate cycle it takes two 16-bit signed fractions and multiplies them. It drops the redundant sign bit of the product by shifting it left one place, then sign-extends it to 36 bits. The result is added to the accumulator, or subtracted from it when the subtract control is high. The low 32 bits of the accumulator are its working part, a 32-bit signed fraction. The top four bits are guard bits that absorb growth during long sums.

Two sticky flags record trouble. The extension flag rises when a result no longer fits the 32-bit working part. The top flag rises when a result overflows the full 36-bit register. When the first overflow occurs, the accumulator's sign bit from before that operation is stored. A read port returns the working part. When saturate mode is on and either flag is set, the read returns the largest positive or largest negative 32-bit fraction instead, chosen by the stored sign. Clear and load commands reset the flags. Clear has priority over load, and load has priority over accumulate.

Top module: `sat_mac_acc`

## Requirements
- R1: After reset the accumulator is zero, both flags are low and the read port returns 0x00000000.
- R2: With `op_valid` high and `op_sub` low, the accumulator becomes acc + sext36(2·a·b), wrapped to 36 bits, where a and b are two's-complement 16-bit values.
- R3: With `op_valid` high and `op_sub` high, the accumulator becomes acc − sext36(2·a·b), wrapped to 36 bits.
- R4: `acc_clr` high zeroes the accumulator and both flags on the next edge, whatever `acc_ld` and `op_valid` are.
- R5: `acc_ld` high with `acc_clr` low loads sext36(`ld_data`) and clears both flags, whatever `op_valid` is.
- R6: `ext_ovf` is set by an accumulate whose 36-bit result lies outside [−2^31, 2^31−1], that is when bits 35..31 are not all equal. It then stays set until a clear or load.
- R7: `acc_ovf` is set by an accumulate whose exact result lies outside [−2^35, 2^35−1]. It then stays set until a clear or load.
- R8: When `sat_mode` is low, or both flags are low, `acc_rd` equals accumulator bits 31..0.
- R9: When `sat_mode` is high and a flag is set, `acc_rd` is 0x7FFFFFFF if the stored sign is 0 and 0x80000000 if it is 1.
- R10: The stored sign is accumulator bit 35 as it was just before the first overflowing accumulate. It holds through later accumulates until a clear or load.
- R11: With `acc_clr`, `acc_ld` and `op_valid` all low, the accumulator and flags keep their values whatever the operands are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_clr | input | 1 | Clear accumulator and flags |
| acc_ld | input | 1 | Load accumulator from `ld_data` |
| ld_data | input | 32 | Signed fraction to load, sign-extended |
| op_valid | input | 1 | Perform one multiply-accumulate step |
| op_sub | input | 1 | Subtract the product instead of adding it |
| op_a | input | 16 | Signed fractional multiplicand |
| op_b | input | 16 | Signed fractional multiplier |
| sat_mode | input | 1 | Saturate reads while a flag is set |
| acc_rd | output | 32 | Working part of the accumulator, clamped when saturating |
| acc_full | output | 36 | Raw accumulator contents |
| ext_ovf | output | 1 | Sticky overflow out of the 32-bit working part |
| acc_ovf | output | 1 | Sticky overflow out of the 36-bit register |

## Verification
The bench sweeps corner operands, including −1.0 times −1.0. That product reaches exactly +1.0, so a design that shifts it in 32 bits turns it into −1.0 and reports no overflow. The load seeds sit at both ends of the 32-bit range, so a single step crosses into the guard bits in each direction. This exposes a misplaced extension-flag test and a saturation value that follows the current sign instead of the stored one. Long runs of full-scale products push the accumulator past bit 35 and then on toward the opposite sign, which catches flags that are not sticky and a stored sign that is recaptured. Commands issued together, and idle cycles with live operands, catch a wrong priority or an accumulate that ignores its enable.

// File: rtl/sat_mac_pkg.sv
package sat_mac_pkg;
  typedef enum logic [1:0] {
    CMD_HOLD  = 2'd0,
    CMD_CLEAR = 2'd1,
    CMD_LOAD  = 2'd2,
    CMD_STEP  = 2'd3
  } acc_cmd_e;
endpackage

// File: rtl/sat_mac_rst_sync.sv
module sat_mac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/sat_mac_mul.sv
module sat_mac_mul #(
  parameter int OP_W  = 16,
  parameter int ACC_W = 36
) (
  input  logic [OP_W-1:0]  mul_a,
  input  logic [OP_W-1:0]  mul_b,
  output logic [ACC_W-1:0] prod_ext
);
  localparam int PROD_W = 2 * OP_W;
  localparam int PAD_W  = ACC_W - PROD_W;

  logic signed [PROD_W-1:0] prod_raw;
  logic        [ACC_W-1:0]  prod_sx;

  // Widen before the fractional shift so +1.0 from (-1)*(-1) stays positive.
  always_comb begin
    prod_raw = $signed(mul_a) * $signed(mul_b);
    prod_sx  = {{PAD_W{prod_raw[PROD_W-1]}}, prod_raw};
    prod_ext = prod_sx << 1;
  end
endmodule

// File: rtl/sat_mac_add.sv
module sat_mac_add #(
  parameter int ACC_W = 36,
  parameter int RD_W  = 32
) (
  input  logic [ACC_W-1:0] acc_in,
  input  logic [ACC_W-1:0] prod_in,
  input  logic             do_sub,
  output logic [ACC_W-1:0] sum_out,
  output logic             ovf_top,
  output logic             ovf_ext
);
  localparam int GUARD_W = ACC_W - RD_W + 1;

  logic [ACC_W:0]     sum_x;
  logic [GUARD_W-1:0] guard;

  always_comb begin
    if (do_sub) sum_x = {acc_in[ACC_W-1], acc_in} - {prod_in[ACC_W-1], prod_in};
    else        sum_x = {acc_in[ACC_W-1], acc_in} + {prod_in[ACC_W-1], prod_in};
    sum_out = sum_x[ACC_W-1:0];
    ovf_top = sum_x[ACC_W] ^ sum_x[ACC_W-1];
    guard   = sum_x[ACC_W-1:RD_W-1];
    ovf_ext = !((&guard) || !(|guard));
  end
endmodule

// File: rtl/sat_mac_rdsat.sv
module sat_mac_rdsat #(
  parameter int ACC_W = 36,
  parameter int RD_W  = 32
) (
  input  logic [ACC_W-1:0] acc_in,
  input  logic             sat_mode,
  input  logic             flag_any,
  input  logic             sign_hold,
  output logic [RD_W-1:0]  rd_out
);
  localparam logic [RD_W-1:0] MAX_POS = {1'b0, {(RD_W-1){1'b1}}};
  localparam logic [RD_W-1:0] MAX_NEG = {1'b1, {(RD_W-1){1'b0}}};

  always_comb begin
    if (sat_mode && flag_any) rd_out = sign_hold ? MAX_NEG : MAX_POS;
    else                      rd_out = acc_in[RD_W-1:0];
  end
endmodule

// File: rtl/sat_mac_acc.sv
module sat_mac_acc
  import sat_mac_pkg::*;
#(
  parameter int OP_W  = 16,
  parameter int RD_W  = 32,
  parameter int ACC_W = 36
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_clr,
  input  logic             acc_ld,
  input  logic [RD_W-1:0]  ld_data,
  input  logic             op_valid,
  input  logic             op_sub,
  input  logic [OP_W-1:0]  op_a,
  input  logic [OP_W-1:0]  op_b,
  input  logic             sat_mode,
  output logic [RD_W-1:0]  acc_rd,
  output logic [ACC_W-1:0] acc_full,
  output logic             ext_ovf,
  output logic             acc_ovf
);
  localparam int EXT_W = ACC_W - RD_W;

  logic             rst_sync_n;
  acc_cmd_e         cmd;
  logic [ACC_W-1:0] prod_ext, sum_val;
  logic             new_top, new_ext;

  logic [ACC_W-1:0] acc_q, acc_d;
  logic             ev_q, ev_d, mv_q, mv_d, sgn_q, sgn_d, reg_en;

  sat_mac_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  sat_mac_mul #(.OP_W(OP_W), .ACC_W(ACC_W)) u_mul (
    .mul_a(op_a), .mul_b(op_b), .prod_ext(prod_ext)
  );

  sat_mac_add #(.ACC_W(ACC_W), .RD_W(RD_W)) u_add (
    .acc_in(acc_q), .prod_in(prod_ext), .do_sub(op_sub),
    .sum_out(sum_val), .ovf_top(new_top), .ovf_ext(new_ext)
  );

  sat_mac_rdsat #(.ACC_W(ACC_W), .RD_W(RD_W)) u_rd (
    .acc_in(acc_q), .sat_mode(sat_mode), .flag_any(ev_q | mv_q),
    .sign_hold(sgn_q), .rd_out(acc_rd)
  );

  // Command priority: clear, then load, then accumulate.
  always_comb begin
    if (acc_clr)       cmd = CMD_CLEAR;
    else if (acc_ld)   cmd = CMD_LOAD;
    else if (op_valid) cmd = CMD_STEP;
    else               cmd = CMD_HOLD;
  end

  always_comb begin
    acc_d  = acc_q;
    ev_d   = ev_q;
    mv_d   = mv_q;
    sgn_d  = sgn_q;
    reg_en = 1'b1;
    case (cmd)
      CMD_CLEAR: begin
        acc_d = '0;
        ev_d  = 1'b0;
        mv_d  = 1'b0;
        sgn_d = 1'b0;
      end
      CMD_LOAD: begin
        acc_d = {{EXT_W{ld_data[RD_W-1]}}, ld_data};
        ev_d  = 1'b0;
        mv_d  = 1'b0;
        sgn_d = 1'b0;
      end
      CMD_STEP: begin
        acc_d = sum_val;
        ev_d  = ev_q | new_ext;
        mv_d  = mv_q | new_top;
        // Capture the sign only on the first overflow since the last clear/load.
        if (!ev_q && !mv_q && (new_ext || new_top)) sgn_d = acc_q[ACC_W-1];
      end
      default: reg_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      acc_q <= '0;
      ev_q  <= 1'b0;
      mv_q  <= 1'b0;
      sgn_q <= 1'b0;
    end else if (reg_en) begin
      acc_q <= acc_d;
      ev_q  <= ev_d;
      mv_q  <= mv_d;
      sgn_q <= sgn_d;
    end
  end

  assign acc_full = acc_q;
  assign ext_ovf  = ev_q;
  assign acc_ovf  = mv_q;
endmodule

// File: rtl/sat_mac_acc_chk.sv
module sat_mac_acc_chk #(
  parameter int RD_W  = 32,
  parameter int ACC_W = 36
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_clr,
  input logic             acc_ld,
  input logic             op_valid,
  input logic [RD_W-1:0]  ld_data,
  input logic             sat_mode,
  input logic [ACC_W-1:0] acc_q,
  input logic             ev_q,
  input logic             mv_q,
  input logic             sgn_q,
  input logic [RD_W-1:0]  acc_rd
);
  localparam logic [RD_W-1:0] MAX_POS = {1'b0, {(RD_W-1){1'b1}}};
  localparam logic [RD_W-1:0] MAX_NEG = {1'b1, {(RD_W-1){1'b0}}};

  p_clr_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clr |=> (acc_q == '0) && !ev_q && !mv_q);

  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_clr && acc_ld) |=>
      (acc_q == {{(ACC_W-RD_W){$past(ld_data[RD_W-1])}}, $past(ld_data)}) && !ev_q && !mv_q);

  p_ext_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_q && !acc_clr && !acc_ld) |=> ev_q);

  p_top_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_q && !acc_clr && !acc_ld) |=> mv_q);

  p_raw_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sat_mode || (!ev_q && !mv_q)) |-> acc_rd == acc_q[RD_W-1:0]);

  p_sat_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_mode && (ev_q || mv_q)) |-> acc_rd == (sgn_q ? MAX_NEG : MAX_POS));

  p_sign_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_q || mv_q) && !acc_clr && !acc_ld) |=> $stable(sgn_q));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_clr && !acc_ld && !op_valid) |=> $stable(acc_q) && $stable(ev_q) && $stable(mv_q));
endmodule

bind sat_mac_acc sat_mac_acc_chk #(.RD_W(RD_W), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .acc_clr(acc_clr), .acc_ld(acc_ld),
  .op_valid(op_valid), .ld_data(ld_data), .sat_mode(sat_mode),
  .acc_q(acc_q), .ev_q(ev_q), .mv_q(mv_q), .sgn_q(sgn_q), .acc_rd(acc_rd)
);

// File: tb/sat_mac_acc_tb_top.sv
`timescale 1ns/1ps
module sat_mac_acc_tb_top;
  logic        clk, rst_n;
  logic        acc_clr, acc_ld, op_valid, op_sub, sat_mode;
  logic [31:0] ld_data;
  logic [15:0] op_a, op_b;
  logic [31:0] acc_rd;
  logic [35:0] acc_full;
  logic        ext_ovf, acc_ovf;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // bench model state
  logic [35:0] m_acc;
  logic        m_ev, m_mv, m_sgn;

  sat_mac_acc dut_i (
    .clk(clk), .rst_n(rst_n), .acc_clr(acc_clr), .acc_ld(acc_ld),
    .ld_data(ld_data), .op_valid(op_valid), .op_sub(op_sub),
    .op_a(op_a), .op_b(op_b), .sat_mode(sat_mode), .acc_rd(acc_rd),
    .acc_full(acc_full), .ext_ovf(ext_ovf), .acc_ovf(acc_ovf)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic cmp(input string tag, input logic [35:0] act, input logic [35:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic longint sx36(input logic [35:0] v);
    return longint'({{28{v[35]}}, v});
  endfunction

  // Apply one command at a negedge, update the model at the edge, return at next negedge.
  task automatic step(input logic c, input logic l, input logic v, input logic s,
                      input logic [15:0] a, input logic [15:0] b, input logic [31:0] d);
    longint prod, full, r;
    logic [35:0] r36;
    logic nev, nmv;
    acc_clr = c; acc_ld = l; op_valid = v; op_sub = s; op_a = a; op_b = b; ld_data = d;
    @(posedge clk);
    if (c) begin
      m_acc = '0; m_ev = 0; m_mv = 0; m_sgn = 0;
    end else if (l) begin
      m_acc = {{4{d[31]}}, d}; m_ev = 0; m_mv = 0; m_sgn = 0;
    end else if (v) begin
      prod = longint'($signed(a)) * longint'($signed(b)) * 2;
      full = s ? sx36(m_acc) - prod : sx36(m_acc) + prod;
      nmv  = (full > 64'sd34359738367) || (full < -64'sd34359738368);
      r36  = full[35:0];
      r    = sx36(r36);
      nev  = (r > 64'sd2147483647) || (r < -64'sd2147483648);
      if (!m_ev && !m_mv && (nev || nmv)) m_sgn = m_acc[35];
      m_ev  = m_ev | nev;
      m_mv  = m_mv | nmv;
      m_acc = r36;
    end
    @(negedge clk);
    acc_clr = 0; acc_ld = 0; op_valid = 0;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] exp_sat;
    sat_mode = 0;
    #1;
    cmp(tag, acc_full, m_acc);
    cmp("R6", {35'd0, ext_ovf}, {35'd0, m_ev});
    cmp("R7", {35'd0, acc_ovf}, {35'd0, m_mv});
    cmp("R8", {4'd0, acc_rd}, {4'd0, m_acc[31:0]});
    sat_mode = 1;
    #1;
    exp_sat = (m_ev || m_mv) ? (m_sgn ? 32'h80000000 : 32'h7FFFFFFF) : m_acc[31:0];
    cmp("R9", {4'd0, acc_rd}, {4'd0, exp_sat});
    sat_mode = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] ops [8];
    logic [31:0] seeds [4];
    ops[0] = 16'h0000; ops[1] = 16'h0001; ops[2] = 16'h7FFF; ops[3] = 16'h8000;
    ops[4] = 16'hFFFF; ops[5] = 16'h4000; ops[6] = 16'hC000; ops[7] = 16'h1234;
    seeds[0] = 32'h00000000; seeds[1] = 32'h7FFFFFFF;
    seeds[2] = 32'h80000000; seeds[3] = 32'h40000000;

    rst_n = 0; acc_clr = 0; acc_ld = 0; op_valid = 0; op_sub = 0;
    op_a = 0; op_b = 0; ld_data = 0; sat_mode = 0;
    m_acc = '0; m_ev = 0; m_mv = 0; m_sgn = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check_all("R1");

    // corner sweep: seed load then one step, add and subtract
    for (int si = 0; si < 4; si++)
      for (int ai = 0; ai < 8; ai++)
        for (int bi = 0; bi < 8; bi++)
          for (int s = 0; s < 2; s++) begin
            step(0, 1, 0, 0, 0, 0, seeds[si]);
            check_all("R5");
            step(0, 0, 1, s[0], ops[ai], ops[bi], 0);
            check_all(s ? "R3" : "R2");
          end

    // long positive run: +1.0 each step pushes past bit 35 and wraps negative
    step(1, 0, 0, 0, 0, 0, 0);
    check_all("R4");
    for (int k = 0; k < 20; k++) begin
      step(0, 0, 1, 0, 16'h8000, 16'h8000, 0);
      check_all("R7");
    end
    sat_mode = 1; #1;
    cmp("R10", {4'd0, acc_rd}, {4'd0, 32'h7FFFFFFF});
    sat_mode = 0;

    // negative overflow then drift positive: stored sign stays negative
    step(0, 1, 0, 0, 0, 0, 32'h80000000);
    step(0, 0, 1, 1, 16'h8000, 16'h8000, 0);
    check_all("R6");
    for (int k = 0; k < 6; k++) begin
      step(0, 0, 1, 0, 16'h7FFF, 16'h7FFF, 0);
      check_all("R10");
    end
    sat_mode = 1; #1;
    cmp("R10", {4'd0, acc_rd}, {4'd0, 32'h80000000});
    sat_mode = 0;

    // idle cycles with live operands
    for (int k = 0; k < 8; k++) begin
      step(0, 0, 0, k[0], ops[k], ops[7-k], 32'h12345678);
      check_all("R11");
    end

    // priority: clear beats load and step, load beats step
    step(0, 1, 0, 0, 0, 0, 32'h5A5A5A5A);
    step(1, 1, 1, 0, 16'h7FFF, 16'h7FFF, 32'h11111111);
    check_all("R4");
    cmp("R4", acc_full, 36'd0);
    step(0, 1, 1, 0, 16'h7FFF, 16'h7FFF, 32'h89ABCDEF);
    check_all("R5");
    cmp("R5", acc_full, 36'hF89ABCDEF);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule